// File: doc/BRIEF.md
# Bit-Slip Word Realignment Unit

This block turns one serial bit stream into parallel words of a fixed width and lets the surrounding logic move the word boundary. Each accepted slip request adds one bit of latency to the stream, so the word framing moves by one position. Logic outside the block repeats this until the framing is correct, and so cancels channel-to-channel skew across several lanes. The word width (the deserialisation factor) is a parameter. Deciding when to slip, for example by searching for a training pattern, is left to the user.

Everything runs on one clock at the serial bit rate. An internal phase counter marks every FACTOR-th cycle as a word tick. The slip control is sampled only on word ticks and acts only on its rising edge. After an accepted slip the unit marks the following words as not valid until the new framing has settled. It also raises a flag when the slip count wraps from FACTOR-1 back to zero.

Top module: `bitslip_realign`

## Requirements
- R1: While `rst` is high, `par_word`, `par_valid`, `word_stb` and `slip_wrap` are all 0.
- R2: `word_stb` pulses for one cycle every FACTOR cycles. With the slip count at zero, `par_word` holds the last FACTOR serial bits, the earliest in bit FACTOR-1 and the latest in bit 0. `par_word`, `par_valid` and `slip_wrap` change only in a `word_stb` cycle.
- R3: With slip count s (0 to FACTOR-1), bit j of the word issued on the tick at serial cycle n equals the serial bit received at cycle n-j-s.
- R4: `slip_req` acts only on its rising edge as seen at successive word ticks. Holding it high for many words causes exactly one slip.
- R5: The word issued on the tick that accepts a slip is valid. The next three words are issued with `par_valid` low. The fourth word after the accepting tick is valid again, and a new rising edge on that same tick is accepted.
- R6: A rising edge of `slip_req` seen while the three-word settling window is running is ignored. It neither slips nor extends the window.
- R7: The slip count wraps from FACTOR-1 to 0. `slip_wrap` goes high on the slip that causes this wrap and stays high until the next accepted slip, which clears it unless that slip wraps again.
- R8: `slip_req` is sampled only on word ticks. A pulse that starts and ends between two ticks has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_in | input | 1 | Serial data bit, one per clock |
| slip_req | input | 1 | Slip control, acts on its rising edge at word ticks |
| par_word | output | FACTOR | Assembled parallel word |
| par_valid | output | 1 | Word framing is settled and the word is usable |
| word_stb | output | 1 | One-cycle pulse when a new word is presented |
| slip_wrap | output | 1 | Slip count has wrapped to zero since the last slip |

## Verification
Two events can fall on the same word tick: the settling window ends, and a new slip request is accepted. The bench provokes this by raising `slip_req` on exactly the fourth tick after an accepted slip, with the control low on the tick before. It expects that tick's word to be valid and correct under the old slip count, and the next three words to be invalid. Random request traffic, together with short pulses between ticks, is compared word by word against a bench model of the slip count, the settling window and the wrap flag.

// File: rtl/bitslip_pkg.sv
package bitslip_pkg;

    // Words that the framing takes to settle after a slip, counted from the
    // accepting tick; the word on the accepting tick itself is still valid.
    localparam int unsigned SETTLE_WORDS_DEF = 4;

    // Slip control state
    typedef enum logic [0:0] {
        ALIGN_IDLE   = 1'b0,
        ALIGN_SETTLE = 1'b1
    } align_state_e;

    // Decoded event on a word tick
    typedef struct packed {
        logic accept;   // rising edge taken this tick
        logic wraps;    // the accepted slip returns the count to zero
    } slip_event_t;

    // Modulo increment used by the slip counter
    function automatic int unsigned wrap_next(input int unsigned cur,
                                              input int unsigned limit);
        return (cur + 1 >= limit) ? 0 : cur + 1;
    endfunction

endpackage

// File: rtl/bitslip_phase.sv
module bitslip_phase #(
    parameter int unsigned FACTOR = 4
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int unsigned PW = (FACTOR > 1) ? $clog2(FACTOR) : 1;
    localparam logic [PW-1:0] LAST = PW'(FACTOR - 1);

    logic [PW-1:0] ph_q;

    // Position of the current serial bit inside the word
    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q <= '0;
        end else if (ph_q == LAST) begin
            ph_q <= '0;
        end else begin
            ph_q <= ph_q + 1'b1;
        end
    end

    assign tick = (ph_q == LAST);

endmodule

// File: rtl/bitslip_ctrl.sv
module bitslip_ctrl
    import bitslip_pkg::*;
#(
    parameter int unsigned FACTOR       = 4,
    parameter int unsigned SETTLE_WORDS = SETTLE_WORDS_DEF
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       tick,
    input  logic                       slip_req,
    output logic [$clog2(FACTOR)-1:0]  slip_cnt,
    output logic                       slip_wrap,
    output logic                       word_ok
);
    localparam int unsigned CW = $clog2(FACTOR);
    localparam int unsigned LW = (SETTLE_WORDS > 2) ? $clog2(SETTLE_WORDS) : 1;

    logic          req_q;      // control level seen on the previous tick
    align_state_e  st_q;
    logic [LW-1:0] left_q;     // invalid words still to issue
    slip_event_t   ev;

    always_comb begin
        ev.accept = tick && slip_req && !req_q && (st_q == ALIGN_IDLE);
        ev.wraps  = (slip_cnt == CW'(FACTOR - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q     <= 1'b0;
            st_q      <= ALIGN_IDLE;
            left_q    <= '0;
            slip_cnt  <= '0;
            slip_wrap <= 1'b0;
        end else if (tick) begin
            req_q <= slip_req;
            if (ev.accept) begin
                slip_cnt  <= CW'(wrap_next(int'(slip_cnt), FACTOR));
                slip_wrap <= ev.wraps;
                st_q      <= ALIGN_SETTLE;
                left_q    <= LW'(SETTLE_WORDS - 1);
            end else if (st_q == ALIGN_SETTLE) begin
                if (left_q == LW'(1)) begin
                    st_q <= ALIGN_IDLE;
                end
                left_q <= left_q - 1'b1;
            end
        end
    end

    // The word issued on a tick is usable while no settling is in progress
    assign word_ok = (st_q == ALIGN_IDLE);

endmodule

// File: rtl/bitslip_tapline.sv
module bitslip_tapline #(
    parameter int unsigned FACTOR = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      ser_in,
    input  logic [$clog2(FACTOR)-1:0] slip_cnt,
    output logic                      dly_bit
);
    localparam int unsigned HW = FACTOR - 1;

    logic [HW-1:0]     hist_q;   // bit 0 is the most recent past bit
    logic [FACTOR-1:0] taps;

    generate
        if (HW > 1) begin : g_wide
            always_ff @(posedge clk) begin
                if (rst) hist_q <= '0;
                else     hist_q <= {hist_q[HW-2:0], ser_in};
            end
        end else begin : g_narrow
            always_ff @(posedge clk) begin
                if (rst) hist_q <= '0;
                else     hist_q <= ser_in;
            end
        end
    endgenerate

    // Tap s delays the stream by s bits
    assign taps    = {hist_q, ser_in};
    assign dly_bit = taps[slip_cnt];

endmodule

// File: rtl/bitslip_gather.sv
module bitslip_gather #(
    parameter int unsigned FACTOR = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              dly_bit,
    input  logic              word_ok,
    output logic [FACTOR-1:0] par_word,
    output logic              par_valid,
    output logic              word_stb
);
    localparam int unsigned SW = FACTOR - 1;

    logic [SW-1:0] sh_q;   // earlier bits of the word being built

    generate
        if (SW > 1) begin : g_wide
            always_ff @(posedge clk) begin
                if (rst) sh_q <= '0;
                else     sh_q <= {sh_q[SW-2:0], dly_bit};
            end
        end else begin : g_narrow
            always_ff @(posedge clk) begin
                if (rst) sh_q <= '0;
                else     sh_q <= dly_bit;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            par_word  <= '0;
            par_valid <= 1'b0;
            word_stb  <= 1'b0;
        end else begin
            word_stb <= tick;
            if (tick) begin
                par_word  <= {sh_q, dly_bit};
                par_valid <= word_ok;
            end
        end
    end

endmodule

// File: rtl/bitslip_realign.sv
module bitslip_realign
    import bitslip_pkg::*;
#(
    parameter int unsigned FACTOR       = 4,
    parameter int unsigned SETTLE_WORDS = SETTLE_WORDS_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_in,
    input  logic              slip_req,
    output logic [FACTOR-1:0] par_word,
    output logic              par_valid,
    output logic              word_stb,
    output logic              slip_wrap
);
    localparam int unsigned CW = $clog2(FACTOR);

    logic          tick;
    logic [CW-1:0] slip_cnt;
    logic          word_ok;
    logic          dly_bit;

    bitslip_phase #(.FACTOR(FACTOR)) u_phase (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    bitslip_ctrl #(.FACTOR(FACTOR), .SETTLE_WORDS(SETTLE_WORDS)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .slip_req  (slip_req),
        .slip_cnt  (slip_cnt),
        .slip_wrap (slip_wrap),
        .word_ok   (word_ok)
    );

    bitslip_tapline #(.FACTOR(FACTOR)) u_tap (
        .clk      (clk),
        .rst      (rst),
        .ser_in   (ser_in),
        .slip_cnt (slip_cnt),
        .dly_bit  (dly_bit)
    );

    bitslip_gather #(.FACTOR(FACTOR)) u_gather (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .dly_bit   (dly_bit),
        .word_ok   (word_ok),
        .par_word  (par_word),
        .par_valid (par_valid),
        .word_stb  (word_stb)
    );

endmodule

// File: rtl/bitslip_realign_chk.sv
module bitslip_realign_chk #(
    parameter int unsigned FACTOR       = 4,
    parameter int unsigned SETTLE_WORDS = 4
) (
    input logic              clk,
    input logic              rst,
    input logic [FACTOR-1:0] par_word,
    input logic              par_valid,
    input logic              word_stb,
    input logic              slip_wrap
);
    logic [7:0] run_q;   // consecutive invalid words seen so far

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
        end else if (word_stb) begin
            if (par_valid)             run_q <= '0;
            else if (run_q != 8'hFF)   run_q <= run_q + 1'b1;
        end
    end

    assert_stb_single_R2: assert property (@(posedge clk) disable iff (rst)
        word_stb |=> !word_stb);

    assert_word_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !word_stb |-> $stable(par_word));

    assert_valid_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !word_stb |-> $stable(par_valid));

    assert_wrap_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !word_stb |-> $stable(slip_wrap));

    // A slip is only accepted in a settled state, so its word is valid
    assert_wrap_on_valid_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(slip_wrap) |-> par_valid);

    // Requests during settling cannot stretch the invalid run
    assert_settle_len_R6: assert property (@(posedge clk) disable iff (rst)
        (word_stb && !par_valid) |-> (run_q < 8'(SETTLE_WORDS - 1)));

endmodule

bind bitslip_realign bitslip_realign_chk #(
    .FACTOR       (FACTOR),
    .SETTLE_WORDS (SETTLE_WORDS)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .par_word  (par_word),
    .par_valid (par_valid),
    .word_stb  (word_stb),
    .slip_wrap (slip_wrap)
);

// File: tb/tb_bitslip_realign.sv
module tb_bitslip_realign;

    localparam int F          = 4;
    localparam int SW         = 4;
    localparam int CLK_PERIOD = 10;
    localparam int NB         = 8192;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         ser_in = 1'b0;
    logic         slip_req = 1'b0;
    logic [F-1:0] par_word;
    logic         par_valid, word_stb, slip_wrap;

    bitslip_realign #(.FACTOR(F), .SETTLE_WORDS(SW)) dut (
        .clk       (clk),
        .rst       (rst),
        .ser_in    (ser_in),
        .slip_req  (slip_req),
        .par_word  (par_word),
        .par_valid (par_valid),
        .word_stb  (word_stb),
        .slip_wrap (slip_wrap)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int   n_chk = 0, n_fail = 0;
    bit   done = 0;
    logic bits [NB];
    int   k = 0;
    // bench model of the slip logic
    int   m_s = 0, m_left = 0;
    bit   m_idle = 1, m_wrap = 0, m_reqq = 0, cur_req = 0;
    int   run = 0, last_run = 0, inval_seg = 0, wrap_seen = 0;
    int   cs = 0, gap = 0;
    bit   first_stb = 1, glitch_on = 0, random_mode = 0;
    int   plan [$];

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [F-1:0] exp_word(input int n, input int s);
        logic [F-1:0] w;
        for (int j = 0; j < F; j++) begin
            int idx;
            idx  = n - j - s;
            w[j] = (idx < 0) ? 1'b0 : bits[idx];
        end
        return w;
    endfunction

    task automatic on_word();
        int n;
        logic [F-1:0] ew;
        n = k - 1;
        if (!first_stb) chk(gap == F, "R2", "strobe spacing", gap, F);
        first_stb = 0;
        chk(par_valid == m_idle, "R5", "valid flag", par_valid, m_idle);
        if (m_idle) begin
            ew = exp_word(n, m_s);
            chk(par_word == ew, (m_s > 0) ? "R3" : "R2", "word", par_word, ew);
        end
        if (!par_valid) begin
            run++;
            inval_seg++;
        end else begin
            if (run > 0) last_run = run;
            run = 0;
        end
        // apply the request level sampled on this tick
        if (cur_req && !m_reqq && m_idle) begin
            m_wrap = (m_s == F - 1);
            m_s    = (m_s + 1) % F;
            m_idle = 0;
            m_left = SW - 1;
        end else if (!m_idle) begin
            if (m_left == 1) m_idle = 1;
            m_left--;
        end
        m_reqq = cur_req;
        chk(slip_wrap == m_wrap, "R7", "wrap flag", slip_wrap, m_wrap);
        if (slip_wrap) wrap_seen++;
        if (plan.size() > 0)  cur_req = plan.pop_front() != 0;
        else if (random_mode) cur_req = ($urandom_range(0, 2) == 0);
        else                  cur_req = 0;
        slip_req = cur_req;
    endtask

    task automatic step();
        @(negedge clk);
        gap++;
        if (word_stb) begin
            on_word();
            gap = 0;
            cs  = 0;
        end else begin
            cs++;
            // short pulse that never reaches a tick (R8)
            if (glitch_on && !cur_req && cs == 1) slip_req = 1'b1;
            if (cs == 2) slip_req = cur_req;
        end
        if (k < NB) begin
            bits[k] = 1'($urandom_range(0, 1));
            ser_in  = bits[k];
            k++;
        end
    endtask

    task automatic run_words(input int nw);
        int c;
        c = 0;
        while (c < nw) begin
            step();
            if (word_stb) c++;
        end
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        chk(par_word == 0,  "R1", "reset word",  par_word, 0);
        chk(par_valid == 0, "R1", "reset valid", par_valid, 0);
        chk(word_stb == 0,  "R1", "reset stb",   word_stb, 0);
        chk(slip_wrap == 0, "R1", "reset wrap",  slip_wrap, 0);
        rst     = 1'b0;
        bits[0] = 1'($urandom_range(0, 1));
        ser_in  = bits[0];
        k       = 1;

        run_words(6);                                   // R2 plain framing

        plan = '{1, 0, 0, 0, 0, 0, 0};                  // single slip, R5
        run_words(8);
        chk(last_run == 3, "R5", "invalid run after slip", last_run, 3);

        inval_seg = 0;                                  // held high, R4
        for (int i = 0; i < 10; i++) plan.push_back(1);
        for (int i = 0; i < 6; i++)  plan.push_back(0);
        run_words(17);
        chk(inval_seg == 3, "R4", "invalid words for held level", inval_seg, 3);

        inval_seg = 0;                                  // edge in window, R6
        plan = '{1, 0, 1, 1, 1, 0, 0, 0, 0, 0};
        run_words(11);
        chk(inval_seg == 3, "R6", "invalid words with ignored edge", inval_seg, 3);

        inval_seg = 0;                                  // settle end + new accept, R5
        plan = '{1, 0, 0, 0, 1, 0, 0, 0, 0, 0};
        run_words(11);
        chk(inval_seg == 6, "R5", "back-to-back slips", inval_seg, 6);

        wrap_seen = 0;                                  // wrap, R7
        for (int i = 0; i < F; i++) plan = {plan, 1, 0, 0, 0};
        plan = {plan, 0, 0};
        run_words(4 * F + 3);
        chk(wrap_seen > 0, "R7", "wrap flag seen", wrap_seen, 1);

        inval_seg = 0;                                  // pulses between ticks, R8
        glitch_on = 1;
        run_words(8);
        chk(inval_seg == 0, "R8", "no slip from short pulses", inval_seg, 0);

        random_mode = 1;                                // mixed traffic
        run_words(400);
        random_mode = 0;
        glitch_on   = 0;
        run_words(6);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R2 watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule